// File: doc/BRIEF.md
# Byte-to-RGB Pixel Packer

This block sits in the pixel clock domain at the front of a video capture path. It takes a narrow byte stream that carries colour samples one after another, together with a line-valid qualifier and a frame-sync marker. It gathers each run of `CHN` consecutive valid bytes into one wide pixel word and raises a one-cycle write strobe for every word it completes. With the defaults, three 8-bit bytes form one 24-bit RGB word.

Grouping is tied to line boundaries. The first valid byte after line-valid rises is always channel 0. If line-valid drops in the middle of a group, the partial group is discarded, so a missing byte can never shift colour channels into the next line. Frame-sync goes through the same number of register stages as the data path, so it stays aligned with the packed words. A parameter chooses whether the earliest byte of a group lands in the most significant or the least significant field of the word.

Top module: `rgb_byte_packer`

## Requirements
- R1: While `rst_n` is low, `word_out`, `word_wr` and `frame_sync_out` are all zero. Reset is asynchronous and clears them without waiting for a clock edge.
- R2: With the default ordering, the earliest byte of a group appears in `word_out[23:16]`, the middle byte in `[15:8]` and the latest byte in `[7:0]`. A byte counts as part of a group when `line_vld` is high at the clock edge that samples it.
- R3: `word_wr` is high for exactly one cycle per completed group. It rises on the second rising edge after the edge that sampled the group's last byte, and `word_out` shows that group's word in the same cycle.
- R4: A line of `3*W` valid bytes in a row produces exactly `W` strobes.
- R5: When `line_vld` goes low with one or two bytes of a group collected, those bytes produce no strobe. The next valid byte starts a new group as channel 0.
- R6: Bytes sampled while `line_vld` is low cause no strobe. `word_out` keeps its last value in every cycle where `word_wr` is low.
- R7: `frame_sync_out` equals `frame_sync` as sampled two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_in | input | DW (8) | One colour sample per clock |
| line_vld | input | 1 | High while `byte_in` carries active line data |
| frame_sync | input | 1 | Frame marker, passed through with the data-path lag |
| word_out | output | CHN*DW (24) | Packed pixel word, held between strobes |
| word_wr | output | 1 | One-cycle strobe marking a new `word_out` |
| frame_sync_out | output | 1 | `frame_sync` delayed by two clocks |

## Verification
The data path has two register stages, so a word is due on the second rising edge after the edge that sampled its last byte. Frame-sync follows the same two-edge lag. Inputs change on the falling edge and outputs are read 1 ns after each rising edge. A cycle-stepped reference in the bench applies the same two-edge lag to decide, for every cycle, whether a strobe is expected, which word is expected and which frame-sync level is expected. Reset is checked while it is held and immediately after it is asserted, with no clock edge in between, since clearing is asynchronous.

// File: rtl/pk_pkg.sv
package pk_pkg;

   // Default geometry: 8-bit samples, three channels per pixel.
   localparam int unsigned PK_DEF_DW  = 8;
   localparam int unsigned PK_DEF_CHN = 3;

   // Placement of the earliest byte of a group inside the packed word.
   typedef enum logic {
      PK_FIRST_MSB = 1'b0,
      PK_FIRST_LSB = 1'b1
   } pk_order_e;

endpackage

// File: rtl/pk_byte_shifter.sv
// Free-running byte history: tap 0 is the byte sampled at the last edge,
// tap k the byte sampled k edges earlier.
module pk_byte_shifter #(
   parameter int unsigned DW  = 8,
   parameter int unsigned CHN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     din,
   output logic [CHN*DW-1:0] taps
);

   genvar k;
   generate
      for (k = 0; k < CHN; k++) begin : g_stage
         logic [DW-1:0] src;
         if (k == 0) begin : g_head
            assign src = din;
         end else begin : g_body
            assign src = taps[(k-1)*DW +: DW];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) taps[k*DW +: DW] <= '0;
            else        taps[k*DW +: DW] <= src;
         end
      end
   endgenerate

endmodule

// File: rtl/pk_phase_ctr.sv
// Channel position within the current group. Held at channel 0 whenever
// line-valid is low, so each line starts a fresh group.
module pk_phase_ctr #(
   parameter int unsigned CHN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lv,
   output logic grp_done
);

   localparam int unsigned CW = (CHN > 1) ? $clog2(CHN) : 1;
   localparam logic [CW-1:0] LAST = CW'(CHN - 1);

   logic [CW-1:0] ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= '0;
         grp_done <= 1'b0;
      end else if (lv) begin
         grp_done <= (ph == LAST);
         ph       <= (ph == LAST) ? '0 : ph + 1'b1;
      end else begin
         ph       <= '0;
         grp_done <= 1'b0;
      end
   end

endmodule

// File: rtl/pk_word_latch.sv
// Captures the byte history into the output word when a group completes.
module pk_word_latch #(
   parameter int unsigned      DW    = 8,
   parameter int unsigned      CHN   = 3,
   parameter pk_pkg::pk_order_e ORDER = pk_pkg::PK_FIRST_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHN*DW-1:0] taps,
   input  logic              load,
   output logic [CHN*DW-1:0] word,
   output logic              wr
);

   logic [CHN*DW-1:0] arranged;

   genvar j;
   generate
      for (j = 0; j < CHN; j++) begin : g_field
         if (ORDER == pk_pkg::PK_FIRST_MSB) begin : g_msb
            // oldest tap (CHN-1) ends up in the top field
            assign arranged[j*DW +: DW] = taps[j*DW +: DW];
         end else begin : g_lsb
            assign arranged[j*DW +: DW] = taps[(CHN-1-j)*DW +: DW];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
         wr   <= 1'b0;
      end else begin
         wr <= load;
         if (load) word <= arranged;
      end
   end

endmodule

// File: rtl/pk_delay_line.sv
// Plain register pipeline of DEPTH stages.
module pk_delay_line #(
   parameter int unsigned W     = 1,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] pipe [DEPTH];

   genvar s;
   generate
      for (s = 0; s < DEPTH; s++) begin : g_pipe
         logic [W-1:0] nxt;
         if (s == 0) begin : g_first
            assign nxt = d;
         end else begin : g_next
            assign nxt = pipe[s-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= nxt;
         end
      end
   endgenerate

   assign q = pipe[DEPTH-1];

endmodule

// File: rtl/rgb_byte_packer.sv
module rgb_byte_packer #(
   parameter int unsigned       DW    = pk_pkg::PK_DEF_DW,
   parameter int unsigned       CHN   = pk_pkg::PK_DEF_CHN,
   parameter pk_pkg::pk_order_e ORDER = pk_pkg::PK_FIRST_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     byte_in,
   input  logic              line_vld,
   input  logic              frame_sync,
   output logic [CHN*DW-1:0] word_out,
   output logic              word_wr,
   output logic              frame_sync_out
);

   localparam int unsigned WW       = CHN * DW;
   // one stage collects the group, one stage latches the word
   localparam int unsigned SYNC_LAG = 2;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("rgb_byte_packer: DW must be at least 1");
      end
      if (CHN < 2) begin : g_bad_chn
         $error("rgb_byte_packer: CHN must be at least 2");
      end
   endgenerate

   logic [WW-1:0] taps;
   logic          grp_done;

   pk_byte_shifter #(.DW(DW), .CHN(CHN)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (byte_in),
      .taps  (taps)
   );

   pk_phase_ctr #(.CHN(CHN)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .lv       (line_vld),
      .grp_done (grp_done)
   );

   pk_word_latch #(.DW(DW), .CHN(CHN), .ORDER(ORDER)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .taps  (taps),
      .load  (grp_done),
      .word  (word_out),
      .wr    (word_wr)
   );

   pk_delay_line #(.W(1), .DEPTH(SYNC_LAG)) u_fsync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (frame_sync),
      .q     (frame_sync_out)
   );

endmodule

// File: rtl/pk_checker.sv
module pk_checker #(
   parameter int unsigned       DW    = 8,
   parameter int unsigned       CHN   = 3,
   parameter pk_pkg::pk_order_e ORDER = pk_pkg::PK_FIRST_MSB
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DW-1:0]     byte_in,
   input logic              line_vld,
   input logic              frame_sync,
   input logic [CHN*DW-1:0] word_out,
   input logic              word_wr,
   input logic              frame_sync_out
);

   // rising edges seen since reset released, saturating
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_clears_chk: assert (word_wr == 1'b0 && word_out == '0 && frame_sync_out == 1'b0);
      end
   end

   // R3
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_wr |=> !word_wr);

   // R5
   strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_wr |-> $past(line_vld, 2));

   // R6
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!word_wr && age != 2'd0) |-> $stable(word_out));

   // R7
   fsync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (frame_sync_out == $past(frame_sync, 2)));

   generate
      if (ORDER == pk_pkg::PK_FIRST_MSB) begin : g_msb
         // R2
         last_byte_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
            word_wr |-> (word_out[DW-1:0] == $past(byte_in, 2)));
      end else begin : g_lsb
         // R2
         last_byte_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
            word_wr |-> (word_out[CHN*DW-1 -: DW] == $past(byte_in, 2)));
      end
   endgenerate

endmodule

bind rgb_byte_packer pk_checker #(.DW(DW), .CHN(CHN), .ORDER(ORDER)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .byte_in        (byte_in),
   .line_vld       (line_vld),
   .frame_sync     (frame_sync),
   .word_out       (word_out),
   .word_wr        (word_wr),
   .frame_sync_out (frame_sync_out)
);

// File: tb/sim_rgb_byte_packer.sv
`timescale 1ns/1ps
module sim_rgb_byte_packer;

   localparam int DW  = 8;
   localparam int CHN = 3;
   localparam int WW  = DW * CHN;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [DW-1:0] byte_in;
   logic          line_vld;
   logic          frame_sync;
   logic [WW-1:0] word_out;
   logic          word_wr;
   logic          frame_sync_out;

   always #2.5 clk = ~clk;

   rgb_byte_packer u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .byte_in        (byte_in),
      .line_vld       (line_vld),
      .frame_sync     (frame_sync),
      .word_out       (word_out),
      .word_wr        (word_wr),
      .frame_sync_out (frame_sync_out)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int strobes = 0;

   // reference state built from the requirements
   logic [DW-1:0] m_b [CHN];
   int            m_cnt;
   logic [WW-1:0] p_word;
   logic          p_v;
   logic [WW-1:0] e_word;
   logic          e_wr;
   logic          fs_q;
   logic          e_fs;

   task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   task automatic m_reset();
      m_cnt = 0; p_word = '0; p_v = 1'b0;
      e_word = '0; e_wr = 1'b0; fs_q = 1'b0; e_fs = 1'b0;
   endtask

   // one clock: drive on falling edge, check 1 ns after rising edge
   task automatic cyc(input logic [DW-1:0] b, input logic lv, input logic fs, input string tag);
      @(negedge clk);
      byte_in = b; line_vld = lv; frame_sync = fs;
      @(posedge clk);
      #1;
      e_wr = p_v;
      if (p_v) e_word = p_word;
      p_v  = 1'b0;
      e_fs = fs_q;
      fs_q = fs;
      if (lv) begin
         m_b[m_cnt] = b;
         if (m_cnt == CHN - 1) begin
            for (int j = 0; j < CHN; j++) p_word[(CHN-1-j)*DW +: DW] = m_b[j];
            p_v   = 1'b1;
            m_cnt = 0;
         end else begin
            m_cnt++;
         end
      end else begin
         m_cnt = 0;
      end
      if (word_wr) strobes++;
      chk(word_wr == e_wr, {tag, " R3 strobe"}, WW'(word_wr), WW'(e_wr));
      chk(word_out == e_word, {tag, " R2 word"}, word_out, e_word);
      chk(frame_sync_out == e_fs, "R7 frame sync", WW'(frame_sync_out), WW'(e_fs));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(8'hEE, 1'b0, 1'b0, "idle");
   endtask

   // R1: outputs held at zero while reset is low
   task automatic t_reset_hold();
      rst_n = 1'b0; byte_in = '0; line_vld = 1'b0; frame_sync = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         byte_in = 8'(i * 37); line_vld = 1'b1; frame_sync = i[0];
         @(posedge clk); #1;
         chk(word_out == '0 && !word_wr && !frame_sync_out, "R1 hold",
             {word_out[WW-3:0], word_wr, frame_sync_out}, '0);
      end
      @(negedge clk);
      line_vld = 1'b0; frame_sync = 1'b0;
      rst_n = 1'b1;
      m_reset();
   endtask

   // R4: full line of 3*W bytes gives W strobes
   task automatic t_full_line(input int w, input int seed);
      int s0;
      s0 = strobes;
      for (int i = 0; i < CHN * w; i++) cyc(8'(seed + i * 13), 1'b1, 1'b0, "R4 line");
      idle(3);
      chk(strobes - s0 == w, "R4 strobe count", WW'(strobes - s0), WW'(w));
   endtask

   // R5: partial group dropped, next line realigned
   task automatic t_partial();
      int s0;
      s0 = strobes;
      for (int i = 0; i < CHN * 2 + 2; i++) cyc(8'(8'h40 + i), 1'b1, 1'b0, "R5 partial");
      idle(3);
      chk(strobes - s0 == 2, "R5 partial count", WW'(strobes - s0), WW'(2));
      s0 = strobes;
      cyc(8'hA1, 1'b1, 1'b0, "R5 gap");
      cyc(8'hA2, 1'b1, 1'b0, "R5 gap");
      cyc(8'hA3, 1'b0, 1'b0, "R5 gap");
      for (int i = 0; i < CHN; i++) cyc(8'(8'hB0 + i), 1'b1, 1'b0, "R5 realign");
      idle(2);
      chk(strobes - s0 == 1, "R5 gap count", WW'(strobes - s0), WW'(1));
      chk(word_out == 24'hB0B1B2, "R5 realigned word", word_out, 24'hB0B1B2);
   endtask

   // R6: bytes outside the line do nothing
   task automatic t_idle_bytes();
      logic [WW-1:0] keep;
      int s0;
      keep = word_out;
      s0 = strobes;
      for (int i = 0; i < 9; i++) cyc(8'(8'h11 * i), 1'b0, 1'b0, "R6 idle");
      chk(strobes == s0, "R6 no strobe", WW'(strobes - s0), '0);
      chk(word_out == keep, "R6 word kept", word_out, keep);
   endtask

   // R7: frame sync patterns
   task automatic t_fsync();
      cyc(8'h00, 1'b0, 1'b1, "R7");
      cyc(8'h00, 1'b0, 1'b0, "R7");
      cyc(8'h00, 1'b0, 1'b1, "R7");
      cyc(8'h00, 1'b0, 1'b1, "R7");
      cyc(8'h00, 1'b0, 1'b1, "R7");
      idle(3);
   endtask

   // R2: explicit field placement of a known triple
   task automatic t_order();
      cyc(8'hC3, 1'b1, 1'b0, "R2");
      cyc(8'h5A, 1'b1, 1'b0, "R2");
      cyc(8'h0F, 1'b1, 1'b0, "R2");
      cyc(8'h00, 1'b0, 1'b0, "R2");
      cyc(8'h00, 1'b0, 1'b0, "R2");
      chk(word_out[23:16] == 8'hC3, "R2 first byte high", WW'(word_out[23:16]), WW'(8'hC3));
      chk(word_out[7:0] == 8'h0F, "R2 last byte low", WW'(word_out[7:0]), WW'(8'h0F));
   endtask

   // R1: asynchronous reset mid-line
   task automatic t_mid_reset();
      for (int i = 0; i < 5; i++) cyc(8'(8'h70 + i), 1'b1, 1'b1, "R1 pre");
      @(negedge clk);
      line_vld = 1'b0; frame_sync = 1'b0;
      #0.5;
      rst_n = 1'b0;
      #0.5;
      chk(word_out == '0 && !word_wr && !frame_sync_out, "R1 async clear",
          {word_out[WW-3:0], word_wr, frame_sync_out}, '0);
      m_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_full_line(2, 8'h90);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      m_reset();
      t_reset_hold();
      idle(2);
      t_order();
      t_full_line(1, 8'h10);
      t_full_line(5, 8'h21);
      t_full_line(16, 8'h05);
      t_partial();
      t_idle_bytes();
      t_fsync();
      t_mid_reset();
      t_idle_bytes();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule